// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned operand by another using the non-restoring method, one quotient bit per step. A clocked control state machine sequences an add/subtract datapath: a start request in the idle state captures both operands, a first forced subtraction follows, and then a loop of test and operate steps runs. In each test step the sign of the partial remainder decides the next quotient bit and whether the next operate step adds or subtracts the divisor.

The parameter `N` is the combined width of the remainder/quotient shift pair. Each operand, the quotient and the remainder are `H = N/2` bits wide. The loop runs `H` test steps. The iteration counter ends at `H-1`, which is `N/2-1`. After the last test step the block raises `stop` for one cycle. The quotient and remainder are valid while `stop` is high and stay valid until the next accepted start. A zero divisor is only flagged. The sequence still runs to completion.

Top module: `nr_divider`

## Requirements
- R1: After synchronous reset, `stop`, `quotient`, `remainder` and `div_zero` are all 0, and the block is idle.
- R2: `start` is accepted only in the idle state, where it captures `dividend` and `divisor`. A `start` pulse, or a change of the operand inputs, while a division is in progress has no effect on that division's results.
- R3: For every nonzero divisor and every H-bit dividend, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor when `stop` is high.
- R4: `stop` is high for exactly one cycle per division. Counting the edge that accepts `start` as edge 1, `stop` is high after edge 2H+2.
- R5: The add/subtract select is a clocked register. The first step forces it to subtract. Each test step sets it to subtract if the partial remainder sign is 0 and to add if the sign is 1. All other states hold it.
- R6: When the partial remainder is negative after the last test step, the divisor is added back, so a completed remainder is always below a nonzero divisor.
- R7: A zero divisor sets `div_zero` = 1 and the division still completes with `stop` at the same latency. In this case `quotient` is all ones and `remainder` equals the dividend.
- R8: `quotient`, `remainder` and `div_zero` hold their values from the end of a division until the next accepted `start`.
- R9: The iteration counter clears in the init state and advances once per test step. The loop leaves for the finish state in the test step where the counter equals H-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, accepted in idle |
| dividend | input | N/2 | Unsigned dividend |
| divisor | input | N/2 | Unsigned divisor |
| quotient | output | N/2 | Quotient result |
| remainder | output | N/2 | Remainder result |
| stop | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divisor was zero for the last division |

## Verification
The hardest cases to reach from the ports are the final add-back correction and the operate steps that take the add direction. Both occur only for particular dividend and divisor pairs. With N=8, the bench therefore runs all 256 operand pairs, zero divisors included. This guarantees that every sign pattern of the partial remainder appears. During about half of these divisions, the bench pulses `start` mid-run with different operands to show that a running division cannot be disturbed. A few idle stretches with changing inputs show that the results are held.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SUB,
    ST_TEST,
    ST_OPER,
    ST_DONE
  } dstate_t;
endpackage

// File: rtl/nr_div_ctrl.sv
module nr_div_ctrl
  import nr_div_pkg::*;
#(
  parameter int H  = 4,
  localparam int CW = $clog2(H + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          acc_neg,
  output dstate_t       state_o,
  output logic          load_o,
  output logic          step_o,
  output logic          step_sub_o,
  output logic          test_o,
  output logic          last_o,
  output logic          sel_o,
  output logic [CW-1:0] cnt_o,
  output logic          stop_o
);
  dstate_t       state_q;
  logic          sel_q;
  logic [CW-1:0] cnt_q;
  logic          last_w;

  assign last_w = (cnt_q == CW'(H - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b1;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) state_q <= ST_INIT;
        ST_INIT: begin
          cnt_q   <= '0;
          state_q <= ST_SUB;
        end
        ST_SUB: begin
          sel_q   <= 1'b1;
          state_q <= ST_TEST;
        end
        ST_TEST: begin
          sel_q   <= ~acc_neg;
          cnt_q   <= cnt_q + 1'b1;
          state_q <= last_w ? ST_DONE : ST_OPER;
        end
        ST_OPER: state_q <= ST_TEST;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign load_o     = (state_q == ST_IDLE) && start;
  assign step_o     = (state_q == ST_SUB) || (state_q == ST_OPER);
  assign step_sub_o = (state_q == ST_SUB) || sel_q;
  assign test_o     = (state_q == ST_TEST);
  assign last_o     = last_w;
  assign sel_o      = sel_q;
  assign cnt_o      = cnt_q;
  assign stop_o     = (state_q == ST_DONE);
endmodule

// File: rtl/nr_div_dp.sv
module nr_div_dp #(
  parameter int H = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [H-1:0] dividend,
  input  logic [H-1:0] divisor,
  input  logic         step,
  input  logic         step_sub,
  input  logic         test,
  input  logic         last,
  output logic         acc_neg,
  output logic [H-1:0] quot,
  output logic [H-1:0] rem,
  output logic [H-1:0] dvs,
  output logic         dz
);
  logic [H:0]   acc_q;
  logic [H-1:0] q_q;
  logic [H-1:0] dvs_q;
  logic         dz_q;
  logic [H:0]   shifted_w;

  // One step: the shifted partial remainder plus or minus the divisor
  function automatic logic [H:0] nr_step(input logic [H:0] sh,
                                         input logic [H-1:0] d,
                                         input logic do_sub);
    return do_sub ? (sh - {1'b0, d}) : (sh + {1'b0, d});
  endfunction

  // Add-back when the final partial remainder is negative
  function automatic logic [H:0] nr_fix(input logic [H:0] a,
                                        input logic [H-1:0] d);
    return a[H] ? (a + {1'b0, d}) : a;
  endfunction

  assign shifted_w = {acc_q[H-1:0], q_q[H-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      q_q   <= '0;
      dvs_q <= '0;
      dz_q  <= 1'b0;
    end else if (load) begin
      acc_q <= '0;
      q_q   <= dividend;
      dvs_q <= divisor;
      dz_q  <= (divisor == '0);
    end else if (step) begin
      acc_q <= nr_step(shifted_w, dvs_q, step_sub);
      q_q   <= q_q << 1;
    end else if (test) begin
      q_q[0] <= ~acc_q[H];
      if (last) acc_q <= nr_fix(acc_q, dvs_q);
    end
  end

  assign acc_neg = acc_q[H];
  assign quot    = q_q;
  assign rem     = acc_q[H-1:0];
  assign dvs     = dvs_q;
  assign dz      = dz_q;
endmodule

// File: rtl/nr_divider.sv
module nr_divider
  import nr_div_pkg::*;
#(
  parameter int N = 8,
  localparam int H  = N / 2,
  localparam int CW = $clog2(H + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [H-1:0] dividend,
  input  logic [H-1:0] divisor,
  output logic [H-1:0] quotient,
  output logic [H-1:0] remainder,
  output logic         stop,
  output logic         div_zero
);
  dstate_t       state_w;
  logic          load_w, step_w, step_sub_w, test_w, last_w, sel_w;
  logic          acc_neg_w;
  logic [CW-1:0] cnt_w;
  logic [H-1:0]  dvs_w;

  nr_div_ctrl #(.H(H)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .acc_neg    (acc_neg_w),
    .state_o    (state_w),
    .load_o     (load_w),
    .step_o     (step_w),
    .step_sub_o (step_sub_w),
    .test_o     (test_w),
    .last_o     (last_w),
    .sel_o      (sel_w),
    .cnt_o      (cnt_w),
    .stop_o     (stop)
  );

  nr_div_dp #(.H(H)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load_w),
    .dividend (dividend),
    .divisor  (divisor),
    .step     (step_w),
    .step_sub (step_sub_w),
    .test     (test_w),
    .last     (last_w),
    .acc_neg  (acc_neg_w),
    .quot     (quotient),
    .rem      (remainder),
    .dvs      (dvs_w),
    .dz       (div_zero)
  );
endmodule

// File: rtl/nr_divider_chk.sv
module nr_divider_chk
  import nr_div_pkg::*;
#(
  parameter int H  = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input dstate_t       state_w,
  input logic          sel_w,
  input logic          acc_neg_w,
  input logic [CW-1:0] cnt_w,
  input logic [H-1:0]  dvs_w,
  input logic [H-1:0]  quotient,
  input logic [H-1:0]  remainder,
  input logic          stop,
  input logic          div_zero
);
  p_stop_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    stop |=> !stop);

  p_sub_forced_r5: assert property (@(posedge clk) disable iff (rst)
    (state_w == ST_SUB) |=> sel_w);

  p_test_sel_r5: assert property (@(posedge clk) disable iff (rst)
    (state_w == ST_TEST) |=> (sel_w == !$past(acc_neg_w)));

  p_sel_held_r5: assert property (@(posedge clk) disable iff (rst)
    (state_w != ST_SUB && state_w != ST_TEST) |=> $stable(sel_w));

  p_rem_below_r6: assert property (@(posedge clk) disable iff (rst)
    (stop && !div_zero) |-> (remainder < dvs_w));

  p_idle_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (state_w == ST_IDLE && start) |=> (state_w == ST_INIT));

  p_results_held_r8: assert property (@(posedge clk) disable iff (rst)
    (state_w == ST_IDLE && !start) |=>
      ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (state_w == ST_INIT) |=> (cnt_w == '0));

  p_cnt_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (state_w == ST_TEST) |=>
      ((state_w == ST_DONE) == ($past(cnt_w) == CW'(H - 1))));

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_w <= CW'(H));
endmodule

bind nr_divider nr_divider_chk #(.H(H), .CW(CW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .state_w   (state_w),
  .sel_w     (sel_w),
  .acc_neg_w (acc_neg_w),
  .cnt_w     (cnt_w),
  .dvs_w     (dvs_w),
  .quotient  (quotient),
  .remainder (remainder),
  .stop      (stop),
  .div_zero  (div_zero)
);

// File: tb/nr_divider_tb_top.sv
`timescale 1ns/1ps
module nr_divider_tb_top;
  localparam int N = 8;
  localparam int H = N / 2;
  localparam int LAT = 2 * H + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [H-1:0] dividend = '0;
  logic [H-1:0] divisor = '0;
  logic [H-1:0] quotient, remainder;
  logic         stop, div_zero;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nr_divider #(.N(N)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .stop      (stop),
    .div_zero  (div_zero)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // One division; optionally disturb it with a second start mid-run
  task automatic run_div(input int a, input int b, input bit disturb);
    int n;
    int eq, er, ez;
    @(negedge clk);
    dividend = H'(a);
    divisor  = H'(b);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!stop && n < 4 * LAT) begin
      if (disturb && n == 3) begin
        start    = 1'b1;
        dividend = H'(~a);
        divisor  = H'(b + 3);
      end else if (disturb && n == 4) begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (b == 0) begin
      eq = (1 << H) - 1; er = a; ez = 1;
    end else begin
      eq = a / b; er = a % b; ez = 0;
    end
    check("R4 latency", n, LAT);
    if (b == 0) begin
      check("R7 quotient", int'(quotient), eq);
      check("R7 remainder", int'(remainder), er);
      check("R7 div_zero", int'(div_zero), ez);
    end else begin
      check(disturb ? "R2 quotient" : "R3 quotient", int'(quotient), eq);
      check(disturb ? "R2 remainder" : "R3 remainder", int'(remainder), er);
      check("R6 remainder below divisor", int'(remainder < H'(b)), 1);
      check("R7 div_zero clear", int'(div_zero), ez);
    end
    @(negedge clk);
    check("R4 stop one cycle", int'(stop), 0);
    check("R8 quotient held", int'(quotient), eq);
    check("R8 remainder held", int'(remainder), er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 stop", int'(stop), 0);
    check("R1 quotient", int'(quotient), 0);
    check("R1 remainder", int'(remainder), 0);
    check("R1 div_zero", int'(div_zero), 0);

    // R3, R6, R7, R9 (loop count shows in latency): exhaustive sweep
    for (int a = 0; a < (1 << H); a++) begin
      for (int b = 0; b < (1 << H); b++) begin
        run_div(a, b, bit'((a + b) & 1));
      end
    end

    // R8: idle with changing operands and no start
    run_div(13, 4, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      dividend = H'(k * 5);
      divisor  = H'(k);
      check("R8 idle quotient", int'(quotient), 3);
      check("R8 idle remainder", int'(remainder), 1);
    end

    // R7 followed by a normal division: flag clears
    run_div(9, 0, 1'b0);
    run_div(15, 15, 1'b0);
    finish_up();
  end
endmodule